// File: doc/BRIEF.md
# User-Mode Floating-Point Register Mode Control

This block sits beside the floating-point unit's control-register file. It holds the mode bit that picks between narrow and wide floating-point register layouts, and it lets unprivileged code flip that bit through two write-only-in-effect alias registers. A privileged configuration write sets or clears a user enable bit. That bit can only stick when the implementation reports support for user-mode switching. An implementation register reports support as a read-only flag.

The mode bit is a two-state machine with the states `MODE_NARROW` and `MODE_WIDE`. The `SET_ALIAS` transition moves it from `MODE_NARROW` to `MODE_WIDE`, and the `CLEAR_ALIAS` transition moves it from `MODE_WIDE` to `MODE_NARROW`. In every other cycle each state holds. An alias write only counts when the feature is active (support and enable both 1) and the named source register is register zero. Any other alias write, and any alias read while the feature is off, is flagged as unpredictable in the same cycle and leaves the state unchanged.

Top module: `fpu_mode_ctl`

## Requirements
- R1: A read of selector 0 returns bit 28 equal to the SUPPORT parameter (1 or 0), bits 15:0 equal to IMPL_REV, and all other bits 0. Writes to selector 0 never change what it reads or the mode.
- R2: `cfg_rdata` has bit 2 as the user enable bit and all other bits 0. A `cfg_we` cycle loads bit 2 of `cfg_wdata` into the enable bit only when SUPPORT is 1. With SUPPORT 0 the enable bit always reads 0.
- R3: With the feature active, a read of selector 1 or selector 4 returns the current mode (1 = wide) in bit 0 with all other bits 0, and does not raise `unpred`.
- R4: With the feature active, a write to selector 1 whose `wr_src` is 0 puts the mode in `MODE_NARROW` (output 0).
- R5: With the feature active, a write to selector 4 whose `wr_src` is 0 puts the mode in `MODE_WIDE` (output 1).
- R6: A write to selector 1 or selector 4 raises `unpred` in its own cycle and leaves the mode unchanged when the feature is inactive or `wr_src` is not 0.
- R7: With the feature inactive, a read of selector 1 or selector 4 returns 0 and raises `unpred` in its own cycle.
- R8: After reset the mode is 0 and the enable bit reads 0.
- R9: A mode change appears on `mode_wide` after the clock edge that ends the strobe cycle, and a read of selector 1 in the following cycle returns the new value. The mode never changes in a cycle without `wr_en`.
- R10: Reads of any selector other than 0, 1 and 4 return 0, writes to them have no effect on the mode, and neither raises `unpred`. `rd_data` is 0 while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Control-register read strobe |
| rd_sel | input | 5 | Control-register selector for the read |
| rd_data | output | DATA_W | Read data, combinational from `rd_sel` |
| wr_en | input | 1 | Control-register write strobe |
| wr_sel | input | 5 | Control-register selector for the write |
| wr_src | input | SRC_W | Index of the general register that supplies the write |
| wr_data | input | DATA_W | Write data (value of the source register) |
| cfg_we | input | 1 | Privileged configuration write strobe |
| cfg_wdata | input | DATA_W | Configuration write data |
| cfg_rdata | output | DATA_W | Configuration register contents |
| mode_wide | output | 1 | Current register mode, 1 = wide |
| unpred | output | 1 | Unpredictable access in this cycle |

## Verification
The bench builds two copies with default widths, one with SUPPORT 1 and one with SUPPORT 0, and drives both with the same stimulus. A model with its own copy of the support flag predicts each copy's results. The sweep covers every one of the 32 selectors, with source indices 0, 1 and 31, under both enable settings and from both starting modes. This reaches every decode path: accepted set and clear, rejected alias writes for both causes, gated alias reads and ignored selectors. The unsupported copy shows that the enable bit cannot be set and that no alias access is ever accepted there.

// File: rtl/fpu_mode_pkg.sv
package fpu_mode_pkg;

    // Selector field width is fixed by the instruction encoding.
    localparam int unsigned SEL_W = 5;

    // Selector values decoded by this block.
    localparam logic [SEL_W-1:0] SEL_IMPL = 5'd0;
    localparam logic [SEL_W-1:0] SEL_CLR  = 5'd1;
    localparam logic [SEL_W-1:0] SEL_SET  = 5'd4;

    typedef enum logic {
        MODE_NARROW = 1'b0,
        MODE_WIDE   = 1'b1
    } fpu_mode_e;

    // Per-cycle access classification produced by the decoder.
    typedef struct packed {
        logic set_req;
        logic clr_req;
        logic wr_bad;
        logic rd_ok;
        logic rd_bad;
    } acc_dec_t;

endpackage

// File: rtl/fpu_mode_cfg.sv
module fpu_mode_cfg #(
    parameter int SUPPORT = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_we,
    input  logic en_wbit,
    output logic user_en
);

    generate
        if (SUPPORT != 0) begin : g_sup
            logic en_q;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    en_q <= 1'b0;
                end else if (cfg_we) begin
                    en_q <= en_wbit;
                end
            end

            assign user_en = en_q;
        end else begin : g_nosup
            logic unused_cfg;

            assign unused_cfg = clk ^ rst_n ^ cfg_we ^ en_wbit;
            assign user_en    = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/fpu_mode_dec.sv
module fpu_mode_dec
    import fpu_mode_pkg::*;
#(
    parameter int SRC_W = 5
) (
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [SRC_W-1:0] wr_src,
    input  logic             rd_en,
    input  logic [SEL_W-1:0] rd_sel,
    input  logic             feat_on,
    output acc_dec_t         dec
);

    logic wr_alias;
    logic rd_alias;
    logic wr_ok;

    always_comb begin
        wr_alias = (wr_sel == SEL_CLR) || (wr_sel == SEL_SET);
        rd_alias = (rd_sel == SEL_CLR) || (rd_sel == SEL_SET);
        wr_ok    = feat_on && (wr_src == '0);

        dec.set_req = wr_en && (wr_sel == SEL_SET) && wr_ok;
        dec.clr_req = wr_en && (wr_sel == SEL_CLR) && wr_ok;
        dec.wr_bad  = wr_en && wr_alias && !wr_ok;
        dec.rd_ok   = rd_en && rd_alias && feat_on;
        dec.rd_bad  = rd_en && rd_alias && !feat_on;
    end

endmodule

// File: rtl/fpu_mode_fsm.sv
module fpu_mode_fsm
    import fpu_mode_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic mode_wide
);

    fpu_mode_e state_q;
    fpu_mode_e state_d;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MODE_NARROW;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: SET_ALIAS and CLEAR_ALIAS; otherwise hold.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_NARROW: begin
                if (set_req) begin
                    state_d = MODE_WIDE;
                end
            end
            MODE_WIDE: begin
                if (clr_req) begin
                    state_d = MODE_NARROW;
                end
            end
            default: state_d = MODE_NARROW;
        endcase
    end

    // Output process.
    always_comb begin
        mode_wide = (state_q == MODE_WIDE);
    end

endmodule

// File: rtl/fpu_mode_ctl.sv
module fpu_mode_ctl
    import fpu_mode_pkg::*;
#(
    parameter int          DATA_W   = 32,
    parameter int          SRC_W    = 5,
    parameter int          SUPPORT  = 1,
    parameter int          SUP_BIT  = 28,
    parameter int          EN_BIT   = 2,
    parameter logic [15:0] IMPL_REV = 16'h0301
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [SRC_W-1:0]  wr_src,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cfg_we,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic              mode_wide,
    output logic              unpred
);

    localparam int REV_W = $bits(IMPL_REV);

    logic     user_en;
    logic     feat_on;
    acc_dec_t dec;
    logic     unused_wdata;

    // Alias writes act on the source index only; the value is not used.
    assign unused_wdata = ^wr_data;
    assign feat_on      = (SUPPORT != 0) && user_en;

    fpu_mode_cfg #(
        .SUPPORT (SUPPORT)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_we  (cfg_we),
        .en_wbit (cfg_wdata[EN_BIT]),
        .user_en (user_en)
    );

    fpu_mode_dec #(
        .SRC_W (SRC_W)
    ) u_dec (
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_src  (wr_src),
        .rd_en   (rd_en),
        .rd_sel  (rd_sel),
        .feat_on (feat_on),
        .dec     (dec)
    );

    fpu_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_req   (dec.set_req),
        .clr_req   (dec.clr_req),
        .mode_wide (mode_wide)
    );

    // Read multiplexer.
    always_comb begin
        rd_data = '0;
        if (rd_en && (rd_sel == SEL_IMPL)) begin
            rd_data[REV_W-1:0] = IMPL_REV;
            rd_data[SUP_BIT]   = (SUPPORT != 0);
        end else if (dec.rd_ok) begin
            rd_data[0] = mode_wide;
        end
    end

    always_comb begin
        cfg_rdata         = '0;
        cfg_rdata[EN_BIT] = user_en;
    end

    assign unpred = dec.wr_bad || dec.rd_bad;

endmodule

// File: rtl/fpu_mode_ctl_chk.sv
module fpu_mode_ctl_chk
    import fpu_mode_pkg::*;
#(
    parameter int          DATA_W   = 32,
    parameter int          SRC_W    = 5,
    parameter int          SUPPORT  = 1,
    parameter int          SUP_BIT  = 28,
    parameter int          EN_BIT   = 2,
    parameter logic [15:0] IMPL_REV = 16'h0301
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic [SEL_W-1:0]  rd_sel,
    input logic [DATA_W-1:0] rd_data,
    input logic              wr_en,
    input logic [SEL_W-1:0]  wr_sel,
    input logic [SRC_W-1:0]  wr_src,
    input logic [DATA_W-1:0] wr_data,
    input logic              cfg_we,
    input logic [DATA_W-1:0] cfg_wdata,
    input logic [DATA_W-1:0] cfg_rdata,
    input logic              mode_wide,
    input logic              unpred
);

    logic on_c;
    logic wr_alias_c;
    logic rd_alias_c;

    assign on_c       = cfg_rdata[EN_BIT];
    assign wr_alias_c = (wr_sel == SEL_CLR) || (wr_sel == SEL_SET);
    assign rd_alias_c = (rd_sel == SEL_CLR) || (rd_sel == SEL_SET);

    p_impl_ro_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_sel == SEL_IMPL) |-> (rd_data[15:0] == IMPL_REV && rd_data[SUP_BIT] == (SUPPORT != 0)));

    p_cfg_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_rdata[EN_BIT] == ((SUPPORT != 0) && $past(cfg_wdata[EN_BIT]))));

    p_rd_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_alias_c && on_c) |-> (rd_data == {{(DATA_W-1){1'b0}}, mode_wide} && !unpred));

    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_CLR && wr_src == '0 && on_c) |=> !mode_wide);

    p_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_SET && wr_src == '0 && on_c) |=> mode_wide);

    p_bad_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_alias_c && !(on_c && wr_src == '0)) |-> unpred);

    p_bad_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_alias_c && !(on_c && wr_src == '0)) |=> $stable(mode_wide));

    p_rd_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_alias_c && !on_c) |-> (rd_data == '0 && unpred));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mode_wide));

    p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && wr_alias_c) && !(rd_en && rd_alias_c)) |-> !unpred);

    p_idle_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rd_data == '0));

endmodule

bind fpu_mode_ctl fpu_mode_ctl_chk #(
    .DATA_W   (DATA_W),
    .SRC_W    (SRC_W),
    .SUPPORT  (SUPPORT),
    .SUP_BIT  (SUP_BIT),
    .EN_BIT   (EN_BIT),
    .IMPL_REV (IMPL_REV)
) u_chk (.*);

// File: tb/fpu_mode_ctl_bench.sv
module fpu_mode_ctl_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] REV = 32'h0000_0301;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic [4:0]  rd_sel = '0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_sel = '0;
    logic [4:0]  wr_src = '0;
    logic [31:0] wr_data = '0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;

    logic [31:0] rd_data   [2];
    logic [31:0] cfg_rdata [2];
    logic        mode_wide [2];
    logic        unpred    [2];

    // Reference model, index 1 = supported copy, index 0 = unsupported copy.
    logic exp_mode [2];
    logic exp_en   [2];

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpu_mode_ctl #(.SUPPORT(1)) u_fpu_mode_ctl (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data[1]),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_src(wr_src), .wr_data(wr_data),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata[1]),
        .mode_wide(mode_wide[1]), .unpred(unpred[1])
    );

    fpu_mode_ctl #(.SUPPORT(0)) u_fpu_mode_ctl_nosup (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data[0]),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_src(wr_src), .wr_data(wr_data),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata[0]),
        .mode_wide(mode_wide[0]), .unpred(unpred[0])
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic bit is_alias(input logic [4:0] s);
        return (s == 5'd1) || (s == 5'd4);
    endfunction

    task automatic set_cfg(input bit v);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = v ? 32'hFFFF_FFFF : 32'h0;
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
        for (int i = 0; i < 2; i++) begin
            exp_en[i] = (i == 1) && v;
            chk(cfg_rdata[i] == {29'h0, exp_en[i], 2'b00}, "R2 cfg enable",
                cfg_rdata[i], {29'h0, exp_en[i], 2'b00});
        end
    endtask

    task automatic do_wr(input logic [4:0] sel, input logic [4:0] src);
        logic  nm [2];
        string rq [2];
        @(negedge clk);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_src  = src;
        wr_data = 32'h5A5A_0000 | {27'h0, sel};
        #1;
        for (int i = 0; i < 2; i++) begin
            bit on  = (i == 1) && exp_en[i];
            bit ok  = on && (src == 5'd0);
            bit bad = is_alias(sel) && !ok;
            nm[i] = exp_mode[i];
            if (bad)                  rq[i] = "R6 rejected alias write";
            else if (sel == 5'd1)     rq[i] = "R4 clear write";
            else if (sel == 5'd4)     rq[i] = "R5 set write";
            else if (sel == 5'd0)     rq[i] = "R1 impl write ignored";
            else                      rq[i] = "R10 other write ignored";
            if (ok && sel == 5'd1) nm[i] = 1'b0;
            if (ok && sel == 5'd4) nm[i] = 1'b1;
            chk(unpred[i] == bad, rq[i], {31'h0, unpred[i]}, {31'h0, bad});
            // R9: no change before the edge that ends the strobe cycle
            chk(mode_wide[i] == exp_mode[i], "R9 mode before edge",
                {31'h0, mode_wide[i]}, {31'h0, exp_mode[i]});
        end
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        for (int i = 0; i < 2; i++) begin
            exp_mode[i] = nm[i];
            chk(mode_wide[i] == exp_mode[i], rq[i], {31'h0, mode_wide[i]}, {31'h0, exp_mode[i]});
        end
    endtask

    task automatic do_rd(input logic [4:0] sel);
        @(negedge clk);
        rd_en  = 1'b1;
        rd_sel = sel;
        #1;
        for (int i = 0; i < 2; i++) begin
            bit          on = (i == 1) && exp_en[i];
            logic [31:0] ed;
            bit          ef;
            string       rq;
            if (sel == 5'd0) begin
                ed = REV | ((i == 1) ? 32'h1000_0000 : 32'h0);
                ef = 1'b0;
                rq = "R1 impl read";
            end else if (is_alias(sel)) begin
                ed = on ? {31'h0, exp_mode[i]} : 32'h0;
                ef = !on;
                rq = on ? "R3/R9 alias read" : "R7 gated alias read";
            end else begin
                ed = 32'h0;
                ef = 1'b0;
                rq = "R10 other read";
            end
            chk(rd_data[i] == ed, rq, rd_data[i], ed);
            chk(unpred[i] == ef, rq, {31'h0, unpred[i]}, {31'h0, ef});
        end
        rd_en = 1'b0;
        #1;
        for (int i = 0; i < 2; i++) begin
            chk(rd_data[i] == 32'h0, "R10 idle read data", rd_data[i], 32'h0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 2; i++) begin
            exp_mode[i] = 1'b0;
            exp_en[i]   = 1'b0;
        end
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        for (int i = 0; i < 2; i++) begin
            chk(mode_wide[i] == 1'b0, "R8 reset mode", {31'h0, mode_wide[i]}, 32'h0);
            chk(cfg_rdata[i] == 32'h0, "R8 reset enable", cfg_rdata[i], 32'h0);
        end
        // Gated accesses straight after reset.
        do_rd(5'd1);
        do_wr(5'd4, 5'd0);

        // Sweep: enable x start mode x selector x source index.
        for (int en = 0; en < 2; en++) begin
            for (int m = 0; m < 2; m++) begin
                for (int s = 0; s < 32; s++) begin
                    for (int k = 0; k < 3; k++) begin
                        logic [4:0] src = (k == 0) ? 5'd0 : ((k == 1) ? 5'd1 : 5'd31);
                        set_cfg(1'b1);
                        do_wr((m == 1) ? 5'd4 : 5'd1, 5'd0);
                        set_cfg(en[0]);
                        do_wr(s[4:0], src);
                        do_rd(5'd1);
                        do_rd(s[4:0]);
                    end
                end
            end
        end

        // Back-to-back toggles with reads in the following cycle.
        set_cfg(1'b1);
        for (int t = 0; t < 4; t++) begin
            do_wr(5'd4, 5'd0);
            do_rd(5'd4);
            do_wr(5'd1, 5'd0);
            do_rd(5'd1);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule